// File: doc/BRIEF.md
# CPU Reset State Sequencer

This block holds the programmer-visible register state of a small 8-bit accumulator CPU: the accumulator, two index registers, the stack pointer and the status register. It also decides how that state behaves across the two kinds of reset. A cold power-on loads fixed values into every register. A warm reset leaves the working registers alone and runs the same entry sequence that interrupts and the break instruction use. In that sequence each of the three stack pushes becomes a bus read, and no data is written.

When the warm sequence finishes, the block raises a one-clock done strobe. The surrounding core uses it to start fetching the reset vector. The execution core loads the registers through a simple load port. The port is honoured only while the sequencer is idle.

Top module: `cpu_rst_seq`

## Requirements
- R1: A clock edge that samples `por` high sets the accumulator, X and Y to 0x00, visible from the next cycle.
- R2: A clock edge that samples `por` high sets the stack pointer to 0xFD.
- R3: A clock edge that samples `por` high sets the status register to 0x34, so bit 2 (interrupt mask) is set.
- R4: A warm reset produces exactly three bus cycles. `bus_req` is high in each of them and `bus_rnw` is 1 (read) in each of them. No bus cycle is ever a write, and `bus_req` stays low outside the sequence.
- R5: During each of the three cycles, `bus_addr` equals 0x0100 plus the stack pointer. The stack pointer then drops by one, so it drops by three in total, wrapping modulo 256 (0x01 gives the addresses 0x0101, 0x0100, 0x01FF and ends at 0xFE).
- R6: On the edge that starts a warm reset, the status register is ORed with 0x04. Every other status bit keeps its value.
- R7: A warm reset leaves the accumulator, X and Y unchanged.
- R8: `seq_done` is high for exactly one cycle, in the cycle right after the third access.
- R9: If `warm_rst` stays high after the sequence, the sequence does not start again. A new sequence needs `warm_rst` to be seen low first.
- R10: `por` takes priority over `warm_rst`. When both are high, or when `por` arrives during a sequence, the result is the power-on values and no further bus cycles.
- R11: With `ld_en` high, `ld_sel` picks the register written from `ld_data`: 0 accumulator, 1 X, 2 Y, 3 stack pointer, 4 status. The write happens only while the sequencer is idle, and it is ignored during a sequence and on the edge a sequence starts.
- R12: A warm reset starts on the first edge at which the idle sequencer samples `warm_rst` high. The three bus cycles occupy the three clocks that follow that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on pulse, synchronous, active high |
| warm_rst | input | 1 | Warm reset request, level, active high |
| ld_en | input | 1 | Register load strobe from the execution core |
| ld_sel | input | 3 | Register select for the load |
| ld_data | input | 8 | Load data |
| bus_req | output | 1 | Bus cycle request |
| bus_rnw | output | 1 | Bus direction, 1 = read |
| bus_addr | output | ADDR_W | Bus address |
| seq_done | output | 1 | One-clock strobe: reset vector fetch may begin |
| reg_a | output | 8 | Accumulator |
| reg_x | output | 8 | Index register X |
| reg_y | output | 8 | Index register Y |
| reg_sp | output | 8 | Stack pointer |
| reg_p | output | 8 | Status register |

## Verification
Two functions can fall in the same cycle. The power-on load can collide with a warm reset, and a register load can collide with an active sequence. The bench raises `por` together with `warm_rst`, and again one cycle into a running sequence. It then expects the power-on values, with the scoreboard holding only the access that came before the power-on. A load driven during the first push cycle must leave the accumulator at its earlier value, while the stack pointer still steps by three.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;

    localparam int unsigned DW = 8;

    localparam logic [DW-1:0] PON_STATUS = 8'h34;
    localparam logic [DW-1:0] PON_SP     = 8'hFD;
    localparam logic [DW-1:0] IMASK_BIT  = 8'h04;
    localparam logic [DW-1:0] STACK_PAGE = 8'h01;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_PUSH = 2'd1,
        SQ_DONE = 2'd2,
        SQ_HOLD = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        SEL_A  = 3'd0,
        SEL_X  = 3'd1,
        SEL_Y  = 3'd2,
        SEL_SP = 3'd3,
        SEL_P  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] x;
        logic [DW-1:0] y;
        logic [DW-1:0] sp;
        logic [DW-1:0] p;
    } cpu_regs_t;

    function automatic cpu_regs_t power_on_regs();
        cpu_regs_t r;
        r.a  = '0;
        r.x  = '0;
        r.y  = '0;
        r.sp = PON_SP;
        r.p  = PON_STATUS;
        return r;
    endfunction

    function automatic logic [2*DW-1:0] stack_addr(input logic [DW-1:0] sp);
        return {STACK_PAGE, sp};
    endfunction

endpackage

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import cpu_rst_pkg::*;
#(
    parameter int unsigned PUSH_CYCLES = 3
) (
    input  logic       clk,
    input  logic       por,
    input  logic       warm_rst,
    output logic       enter,
    output logic       push_act,
    output logic       idle,
    output logic       done
);
    localparam int unsigned CW = (PUSH_CYCLES > 1) ? $clog2(PUSH_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(PUSH_CYCLES - 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (por) begin
            state <= SQ_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (warm_rst) begin
                        state <= SQ_PUSH;
                        cnt   <= '0;
                    end
                end
                SQ_PUSH: begin
                    if (cnt == LAST) state <= SQ_DONE;
                    else             cnt   <= cnt + 1'b1;
                end
                SQ_DONE: state <= SQ_HOLD;
                SQ_HOLD: if (!warm_rst) state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        idle     = (state == SQ_IDLE);
        enter    = idle && warm_rst && !por;
        push_act = (state == SQ_PUSH);
        done     = (state == SQ_DONE);
    end

endmodule

// File: rtl/rst_regfile.sv
module rst_regfile
    import cpu_rst_pkg::*;
(
    input  logic          clk,
    input  logic          por,
    input  logic          enter,
    input  logic          push_act,
    input  logic          idle,
    input  logic          ld_en,
    input  logic [2:0]    ld_sel,
    input  logic [DW-1:0] ld_data,
    output cpu_regs_t     regs
);
    always_ff @(posedge clk) begin
        if (por) begin
            regs <= power_on_regs();
        end else if (enter) begin
            regs.p <= regs.p | IMASK_BIT;
        end else if (push_act) begin
            regs.sp <= regs.sp - 8'd1;
        end else if (ld_en && idle) begin
            case (reg_sel_e'(ld_sel))
                SEL_A:   regs.a  <= ld_data;
                SEL_X:   regs.x  <= ld_data;
                SEL_Y:   regs.y  <= ld_data;
                SEL_SP:  regs.sp <= ld_data;
                SEL_P:   regs.p  <= ld_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rst_bus_drv.sv
module rst_bus_drv
    import cpu_rst_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              push_act,
    input  logic              wr_block,
    input  logic [DW-1:0]     sp,
    output logic              bus_req,
    output logic              bus_rnw,
    output logic [ADDR_W-1:0] bus_addr
);
    always_comb begin
        bus_req  = push_act;
        bus_rnw  = !(push_act && !wr_block);
        bus_addr = push_act ? ADDR_W'(stack_addr(sp)) : '0;
    end

endmodule

// File: rtl/cpu_rst_seq.sv
module cpu_rst_seq
    import cpu_rst_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned PUSH_CYCLES = 3
) (
    input  logic              clk,
    input  logic              por,
    input  logic              warm_rst,
    input  logic              ld_en,
    input  logic [2:0]        ld_sel,
    input  logic [7:0]        ld_data,
    output logic              bus_req,
    output logic              bus_rnw,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              seq_done,
    output logic [7:0]        reg_a,
    output logic [7:0]        reg_x,
    output logic [7:0]        reg_y,
    output logic [7:0]        reg_sp,
    output logic [7:0]        reg_p
);
    logic      enter;
    logic      push_act;
    logic      idle;
    cpu_regs_t regs;

    rst_seq_ctrl #(.PUSH_CYCLES(PUSH_CYCLES)) u_ctrl (
        .clk      (clk),
        .por      (por),
        .warm_rst (warm_rst),
        .enter    (enter),
        .push_act (push_act),
        .idle     (idle),
        .done     (seq_done)
    );

    rst_regfile u_regs (
        .clk      (clk),
        .por      (por),
        .enter    (enter),
        .push_act (push_act),
        .idle     (idle),
        .ld_en    (ld_en),
        .ld_sel   (ld_sel),
        .ld_data  (ld_data),
        .regs     (regs)
    );

    // Reset entry: the push intent of the shared entry sequence is always blocked.
    rst_bus_drv #(.ADDR_W(ADDR_W)) u_bus (
        .push_act (push_act),
        .wr_block (1'b1),
        .sp       (regs.sp),
        .bus_req  (bus_req),
        .bus_rnw  (bus_rnw),
        .bus_addr (bus_addr)
    );

    assign reg_a  = regs.a;
    assign reg_x  = regs.x;
    assign reg_y  = regs.y;
    assign reg_sp = regs.sp;
    assign reg_p  = regs.p;

endmodule

// File: rtl/cpu_rst_seq_chk.sv
module cpu_rst_seq_chk
    import cpu_rst_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              por,
    input logic              ld_en,
    input logic              bus_req,
    input logic              bus_rnw,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              seq_done,
    input logic [7:0]        reg_a,
    input logic [7:0]        reg_x,
    input logic [7:0]        reg_y,
    input logic [7:0]        reg_sp,
    input logic [7:0]        reg_p
);
    AST_POR_GPR_ZERO: assert property (@(posedge clk)
        por |=> (reg_a == 8'h00 && reg_x == 8'h00 && reg_y == 8'h00)); // R1
    AST_POR_SP_LOAD: assert property (@(posedge clk)
        por |=> (reg_sp == PON_SP)); // R2
    AST_POR_STATUS_LOAD: assert property (@(posedge clk)
        por |=> (reg_p == PON_STATUS)); // R3
    AST_ACCESS_IS_READ: assert property (@(posedge clk) disable iff (por)
        bus_req |-> bus_rnw); // R4
    AST_ADDR_FROM_SP: assert property (@(posedge clk) disable iff (por)
        bus_req |-> (bus_addr == ADDR_W'({STACK_PAGE, reg_sp}))); // R5
    AST_SP_STEP_DOWN: assert property (@(posedge clk) disable iff (por)
        bus_req |=> (reg_sp == $past(reg_sp) - 8'd1)); // R5
    AST_MASK_BEFORE_ACCESS: assert property (@(posedge clk) disable iff (por)
        $rose(bus_req) |-> reg_p[2]); // R6
    AST_GPR_HELD: assert property (@(posedge clk) disable iff (por)
        !ld_en |=> ($stable(reg_a) && $stable(reg_x) && $stable(reg_y))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (por)
        seq_done |=> !seq_done); // R8
    AST_DONE_NO_ACCESS: assert property (@(posedge clk) disable iff (por)
        seq_done |-> !bus_req); // R8

endmodule

bind cpu_rst_seq cpu_rst_seq_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/cpu_rst_seq_test.sv
module cpu_rst_seq_test;

    logic        clk = 1'b0;
    logic        por, warm_rst, ld_en;
    logic [2:0]  ld_sel;
    logic [7:0]  ld_data;
    logic        bus_req, bus_rnw, seq_done;
    logic [15:0] bus_addr;
    logic [7:0]  reg_a, reg_x, reg_y, reg_sp, reg_p;

    int          tests = 0;
    int          fails = 0;
    int          done_hi = 0;
    logic [15:0] exp_q[$];
    logic [15:0] mon_e;

    always #2 clk = ~clk;

    cpu_rst_seq uut (
        .clk(clk), .por(por), .warm_rst(warm_rst),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .bus_req(bus_req), .bus_rnw(bus_rnw), .bus_addr(bus_addr),
        .seq_done(seq_done),
        .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y),
        .reg_sp(reg_sp), .reg_p(reg_p)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: every bus cycle must match the next queued expectation (R4, R5).
    always @(negedge clk) begin
        if (bus_req === 1'b1) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R4 unexpected bus cycle actual=%h expected=none", bus_addr);
            end else begin
                mon_e = exp_q.pop_front();
                if (bus_addr !== mon_e || bus_rnw !== 1'b1) begin
                    fails++;
                    $display("FAIL R5 bus access actual=%h/%b expected=%h/1",
                             bus_addr, bus_rnw, mon_e);
                end
            end
        end
        if (seq_done === 1'b1) done_hi++;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [2:0] sel, input logic [7:0] d);
        ld_en = 1'b1; ld_sel = sel; ld_data = d;
        tick(1);
        ld_en = 1'b0;
    endtask

    // Driver: queue the three stack addresses a warm reset must read.
    task automatic expect_entry(input logic [7:0] sp0);
        for (int i = 0; i < 3; i++) begin
            logic [7:0] s;
            s = sp0 - 8'(i);
            exp_q.push_back({8'h01, s});
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        por = 1'b1; warm_rst = 1'b0; ld_en = 1'b0; ld_sel = '0; ld_data = '0;
        tick(2);
        por = 1'b0;
        @(negedge clk);
        chk("R1", "acc after power-on", {8'h0, reg_a}, 16'h0000);
        chk("R1", "x/y after power-on", {reg_x, reg_y}, 16'h0000);
        chk("R2", "sp after power-on", {8'h0, reg_sp}, 16'h00FD);
        chk("R3", "status after power-on", {8'h0, reg_p}, 16'h0034);
        chk("R4", "bus idle", {15'h0, bus_req}, 16'h0000);
        chk("R8", "done idle", {15'h0, seq_done}, 16'h0000);

        tick(0);
        load(3'd0, 8'h5A); load(3'd1, 8'hA5); load(3'd2, 8'h3C); load(3'd4, 8'hC1);
        @(negedge clk);
        chk("R11", "loaded a/x", {reg_a, reg_x}, 16'h5AA5);
        chk("R11", "loaded y/p", {reg_y, reg_p}, 16'h3CC1);

        // First warm reset, held high well past the sequence (R9, R12).
        tick(0);
        done_hi = 0;
        expect_entry(8'hFD);
        warm_rst = 1'b1;
        tick(1);
        ld_en = 1'b1; ld_sel = 3'd0; ld_data = 8'hFF;   // collides with push cycle
        tick(1);
        ld_en = 1'b0;
        tick(8);
        @(negedge clk);
        chk("R4", "all three reads seen", 16'(exp_q.size()), 16'd0);
        chk("R8", "done high cycles", 16'(done_hi), 16'd1);
        chk("R9", "no retrigger while held", {8'h0, reg_sp}, 16'h00FA);
        chk("R5", "sp dropped by three", {8'h0, reg_sp}, 16'h00FA);
        chk("R6", "mask ORed, rest kept", {8'h0, reg_p}, 16'h00C5);
        chk("R7", "a/x kept", {reg_a, reg_x}, 16'h5AA5);
        chk("R7", "y kept", {8'h0, reg_y}, 16'h003C);
        chk("R11", "load during sequence ignored", {8'h0, reg_a}, 16'h005A);

        // Release, then reset again from sp = 0x01 to cross the wrap (R5).
        tick(0);
        warm_rst = 1'b0;
        tick(2);
        load(3'd3, 8'h01);
        expect_entry(8'h01);
        warm_rst = 1'b1;
        tick(6);
        warm_rst = 1'b0;
        tick(2);
        @(negedge clk);
        chk("R5", "sp after wrap", {8'h0, reg_sp}, 16'h00FE);
        chk("R5", "wrap reads consumed", 16'(exp_q.size()), 16'd0);
        chk("R8", "second done pulse", 16'(done_hi), 16'd2);
        chk("R6", "status with mask already set", {8'h0, reg_p}, 16'h00C5);

        // Power-on and warm reset together (R10).
        tick(0);
        load(3'd0, 8'h77);
        warm_rst = 1'b1; por = 1'b1;
        tick(2);
        por = 1'b0; warm_rst = 1'b0;
        tick(3);
        @(negedge clk);
        chk("R10", "acc power-on wins", {8'h0, reg_a}, 16'h0000);
        chk("R10", "sp/p power-on wins", {reg_sp, reg_p}, 16'hFD34);
        chk("R10", "no done on collision", 16'(done_hi), 16'd2);

        // Power-on one cycle into a sequence (R10, R12).
        tick(0);
        exp_q.push_back(16'h01FD);
        warm_rst = 1'b1;
        tick(1);
        por = 1'b1; warm_rst = 1'b0;
        tick(1);
        por = 1'b0;
        tick(3);
        @(negedge clk);
        chk("R12", "first read issued", 16'(exp_q.size()), 16'd0);
        chk("R10", "abort restores sp/p", {reg_sp, reg_p}, 16'hFD34);
        chk("R10", "abort gives no done", 16'(done_hi), 16'd2);

        report();
    end

endmodule